// File: doc/BRIEF.md
# Register-Driven SPI Flash Command Engine

This block lets software run single-lane SPI flash commands one at a time through a small byte-wide register file. Software first loads an opcode byte, a 24-bit address held as three bytes, and up to four data bytes. It then writes a control byte that sets the transfer shape, picks a chip select and sets the go flag. The engine clocks the bytes out in mode 0 at half the bus clock rate, since there is no divider. It stores any bytes read back into the data registers and clears the go flag when the transfer is finished. Software polls that flag to learn when the command is done.

A separate hold register keeps chip selects asserted. Each of its bits, while cleared, keeps one select line low between commands. Software uses this to join two short transfers into one longer frame on the wire, for example a 4-byte address command or a command with dummy bytes.

Top module: `spi_cmd_engine`

## Requirements
- R1: After reset, every register reads 0x00 except the hold register, which reads 0x0F. All chip selects are high, SCK is low and MOSI is low.
- R2: The register offsets are fixed. The opcode is at 0x16. The address is at 0x17 (bits 7:0), 0x18 (bits 15:8) and 0x19 (bits 23:16). The data bytes are at 0x1A to 0x1D. The control byte is at 0x1E and the hold register is at 0x1F. Each register reads back what was written to it, and an unmapped offset reads 0x00.
- R3: The control byte has these fields: bits 2:0 are the data count, bit 3 enables the address phase, bit 4 selects write (1) or read (0), bits 6:5 are the chip-select index, and bit 7 is go/busy. Writing the control byte with bit 7 set starts a transfer. Bit 7 reads 1 while the transfer runs and is cleared by hardware at the end; the other bits keep their values.
- R4: The bytes go out in this order: the opcode first; then, if the address phase is enabled, the bytes at 0x19, 0x18 and 0x17 in that order; then the data bytes. Each byte is sent MSB first.
- R5: SPI mode 0 is used. SCK idles low. MOSI changes only while SCK is low, and MISO is sampled as SCK rises. One SCK period lasts two bus clocks, so every byte takes exactly 8 SCK rising edges.
- R6: In a write transfer, the data bytes are sent starting with offset 0x1A. In a read transfer, MOSI stays low during the data bytes. The received bytes are stored from 0x1A upward in the order they arrive, and any data register beyond the count is left unchanged.
- R7: A data count of 5, 6 or 7 is treated as 4.
- R8: During a transfer only the selected chip select goes low. If that select's hold bit is 1, the select goes high again when the transfer ends.
- R9: A hold bit of 0 drives its chip select low at once and keeps it low across transfers. Writing the bit back to 1 releases the select.
- R10: A write to the control byte while bit 7 is set has no effect.
- R11: Bit 7 clears exactly 16*N bus clocks after the clock edge that started the transfer, where N is the number of bytes on the wire. Polling the control byte every two clocks therefore sees bit 7 clear on poll 8*N+1, which is within 100 polls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, which is also the SPI bit clock source |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from reg_addr |
| spi_sck | output | 1 | SPI clock |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |
| spi_cs_n | output | NUM_CS | Active-low chip selects |

## Verification
The bench builds the engine with its default values: four data bytes and four chip selects. At these sizes it sweeps every combination of address phase, direction and data count from 0 to 4 across all four selects. A flash model on the bench replies with a byte pattern that depends on the position of each byte within the frame. This makes data that lands in the wrong register, or a frame that was not kept open by the hold bit, show up as a wrong value. With this configuration the bench can also reach the count saturation case, a write during busy, and a two-part frame held open by a hold bit.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
  localparam int REG_AW = 5;

  localparam logic [REG_AW-1:0] OFS_OPC  = 5'h16;
  localparam logic [REG_AW-1:0] OFS_ADR0 = 5'h17;
  localparam logic [REG_AW-1:0] OFS_ADR1 = 5'h18;
  localparam logic [REG_AW-1:0] OFS_ADR2 = 5'h19;
  localparam logic [REG_AW-1:0] OFS_DAT0 = 5'h1A;
  localparam logic [REG_AW-1:0] OFS_CTL  = 5'h1E;
  localparam logic [REG_AW-1:0] OFS_HOLD = 5'h1F;

  // control byte, bit 7 down to bit 0
  typedef struct packed {
    logic       go;
    logic [1:0] sel;
    logic       wr;
    logic       adr_en;
    logic [2:0] cnt;
  } ctl_t;
endpackage

// File: rtl/spi_cmd_regs.sv
module spi_cmd_regs
  import spi_cmd_pkg::*;
#(
  parameter int DATA_BYTES = 4,
  parameter int NUM_CS     = 4,
  localparam int IDX_W     = (DATA_BYTES > 1) ? $clog2(DATA_BYTES) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    reg_wr,
  input  logic [REG_AW-1:0]       reg_addr,
  input  logic [7:0]              reg_wdata,
  output logic [7:0]              reg_rdata,
  input  logic                    done,
  input  logic                    rx_we,
  input  logic [IDX_W-1:0]        rx_idx,
  input  logic [7:0]              rx_byte,
  output logic                    start,
  output ctl_t                    ctl,
  output logic [7:0]              opcode,
  output logic [23:0]             addr,
  output logic [8*DATA_BYTES-1:0] data,
  output logic [NUM_CS-1:0]       hold
);
  ctl_t                    ctl_q, ctl_d;
  logic [7:0]              opc_q, opc_d;
  logic [23:0]             adr_q, adr_d;
  logic [8*DATA_BYTES-1:0] dat_q, dat_d;
  logic [NUM_CS-1:0]       hold_q, hold_d;
  logic                    ctl_wr;

  assign ctl_wr = reg_wr && (reg_addr == OFS_CTL);
  assign start  = ctl_wr && reg_wdata[7] && !ctl_q.go;

  always_comb begin
    ctl_d  = ctl_q;
    opc_d  = opc_q;
    adr_d  = adr_q;
    dat_d  = dat_q;
    hold_d = hold_q;
    if (ctl_wr && !ctl_q.go) ctl_d = ctl_t'(reg_wdata);
    if (done) ctl_d.go = 1'b0;
    if (reg_wr) begin
      if (reg_addr == OFS_OPC)  opc_d         = reg_wdata;
      if (reg_addr == OFS_ADR0) adr_d[7:0]    = reg_wdata;
      if (reg_addr == OFS_ADR1) adr_d[15:8]   = reg_wdata;
      if (reg_addr == OFS_ADR2) adr_d[23:16]  = reg_wdata;
      if (reg_addr == OFS_HOLD) hold_d        = reg_wdata[NUM_CS-1:0];
    end
    for (int j = 0; j < DATA_BYTES; j++) begin
      if (reg_wr && (reg_addr == OFS_DAT0 + REG_AW'(j))) dat_d[8*j +: 8] = reg_wdata;
      if (rx_we && (rx_idx == IDX_W'(j)))                dat_d[8*j +: 8] = rx_byte;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q  <= '0;
      opc_q  <= '0;
      adr_q  <= '0;
      dat_q  <= '0;
      hold_q <= '1;
    end else begin
      ctl_q  <= ctl_d;
      opc_q  <= opc_d;
      adr_q  <= adr_d;
      dat_q  <= dat_d;
      hold_q <= hold_d;
    end
  end

  always_comb begin
    reg_rdata = 8'h00;
    if (reg_addr == OFS_OPC)  reg_rdata = opc_q;
    if (reg_addr == OFS_ADR0) reg_rdata = adr_q[7:0];
    if (reg_addr == OFS_ADR1) reg_rdata = adr_q[15:8];
    if (reg_addr == OFS_ADR2) reg_rdata = adr_q[23:16];
    if (reg_addr == OFS_CTL)  reg_rdata = ctl_q;
    if (reg_addr == OFS_HOLD) reg_rdata = 8'(hold_q);
    for (int j = 0; j < DATA_BYTES; j++)
      if (reg_addr == OFS_DAT0 + REG_AW'(j)) reg_rdata = dat_q[8*j +: 8];
  end

  assign ctl    = ctl_q;
  assign opcode = opc_q;
  assign addr   = adr_q;
  assign data   = dat_q;
  assign hold   = hold_q;

  assert_busy_write_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && ctl_q.go) |=> (ctl_q[6:0] == $past(ctl_q[6:0])));
  assert_start_sets_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> ctl_q.go);
endmodule

// File: rtl/spi_cmd_seq.sv
module spi_cmd_seq #(
  parameter int DATA_BYTES = 4,
  localparam int IDX_W     = (DATA_BYTES > 1) ? $clog2(DATA_BYTES) : 1,
  localparam int MAX_TOTAL = 4 + DATA_BYTES,
  localparam int BYTE_W    = $clog2(MAX_TOTAL + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic                    adr_en,
  input  logic                    wr,
  input  logic [2:0]              cnt,
  input  logic [7:0]              opcode,
  input  logic [23:0]             addr,
  input  logic [8*DATA_BYTES-1:0] data,
  input  logic                    miso,
  output logic                    active,
  output logic                    done,
  output logic                    rx_we,
  output logic [IDX_W-1:0]        rx_idx,
  output logic [7:0]              rx_byte,
  output logic                    sck,
  output logic                    mosi
);
  logic              act_q, act_d;
  logic              ph_q, ph_d;
  logic [2:0]        bit_q, bit_d;
  logic [BYTE_W-1:0] idx_q, idx_d;
  logic [7:0]        rx_q, rx_d;
  logic              en;

  logic [BYTE_W-1:0] hdr, dn, last, didx;
  logic              in_data, drive, byte_end;
  logic [7:0]        cur;

  assign hdr      = adr_en ? BYTE_W'(4) : BYTE_W'(1);
  assign dn       = (cnt > 3'(DATA_BYTES)) ? BYTE_W'(DATA_BYTES) : BYTE_W'(cnt);
  assign last     = hdr + dn - BYTE_W'(1);
  assign in_data  = (idx_q >= hdr);
  assign didx     = idx_q - hdr;
  assign byte_end = act_q && ph_q && (bit_q == 3'd7);

  always_comb begin
    cur = opcode;
    if (idx_q != '0) begin
      if (!in_data) begin
        case (idx_q[1:0])
          2'd1:    cur = addr[23:16];
          2'd2:    cur = addr[15:8];
          default: cur = addr[7:0];
        endcase
      end else begin
        cur = 8'h00;
        for (int j = 0; j < DATA_BYTES; j++)
          if (didx == BYTE_W'(j)) cur = data[8*j +: 8];
      end
    end
  end

  assign drive = act_q && (!in_data || wr);
  assign mosi  = drive && cur[~bit_q];
  assign sck   = ph_q;

  always_comb begin
    act_d = act_q;
    ph_d  = ph_q;
    bit_d = bit_q;
    idx_d = idx_q;
    rx_d  = rx_q;
    if (start) begin
      act_d = 1'b1;
      ph_d  = 1'b0;
      bit_d = 3'd0;
      idx_d = '0;
    end else if (act_q) begin
      if (!ph_q) begin
        ph_d = 1'b1;
        rx_d = {rx_q[6:0], miso};
      end else begin
        ph_d  = 1'b0;
        bit_d = bit_q + 3'd1;
        if (bit_q == 3'd7) begin
          idx_d = idx_q + BYTE_W'(1);
          if (idx_q == last) act_d = 1'b0;
        end
      end
    end
  end

  assign en = start || act_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      ph_q  <= 1'b0;
      bit_q <= 3'd0;
      idx_q <= '0;
      rx_q  <= 8'h00;
    end else if (en) begin
      act_q <= act_d;
      ph_q  <= ph_d;
      bit_q <= bit_d;
      idx_q <= idx_d;
      rx_q  <= rx_d;
    end
  end

  assign active  = act_q;
  assign done    = byte_end && (idx_q == last);
  assign rx_we   = byte_end && in_data && !wr;
  assign rx_idx  = didx[IDX_W-1:0];
  assign rx_byte = rx_q;

  assert_sck_idle_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !act_q |-> !sck);
  assert_mosi_quiet_on_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && in_data && !wr) |-> !mosi);
  assert_rx_only_on_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_we |-> !wr);
  assert_done_ends_frame_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !act_q);
endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine
  import spi_cmd_pkg::*;
#(
  parameter int DATA_BYTES = 4,
  parameter int NUM_CS     = 4,
  localparam int IDX_W     = (DATA_BYTES > 1) ? $clog2(DATA_BYTES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [4:0]        reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  output logic              spi_sck,
  output logic              spi_mosi,
  input  logic              spi_miso,
  output logic [NUM_CS-1:0] spi_cs_n
);
  ctl_t                    ctl;
  logic                    start, done, rx_we, seq_act;
  logic [IDX_W-1:0]        rx_idx;
  logic [7:0]              rx_byte, opcode;
  logic [23:0]             addr;
  logic [8*DATA_BYTES-1:0] data;
  logic [NUM_CS-1:0]       hold;

  spi_cmd_regs #(.DATA_BYTES(DATA_BYTES), .NUM_CS(NUM_CS)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .done(done), .rx_we(rx_we),
    .rx_idx(rx_idx), .rx_byte(rx_byte), .start(start), .ctl(ctl),
    .opcode(opcode), .addr(addr), .data(data), .hold(hold)
  );

  spi_cmd_seq #(.DATA_BYTES(DATA_BYTES)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .adr_en(ctl.adr_en), .wr(ctl.wr),
    .cnt(ctl.cnt), .opcode(opcode), .addr(addr), .data(data), .miso(spi_miso),
    .active(seq_act), .done(done), .rx_we(rx_we), .rx_idx(rx_idx),
    .rx_byte(rx_byte), .sck(spi_sck), .mosi(spi_mosi)
  );

  for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
    assign spi_cs_n[i] = !((seq_act && (ctl.sel == 2'(i))) || !hold[i]);
  end

  assert_flag_tracks_engine_R3: assert property (@(posedge clk) disable iff (!rst_n)
    seq_act == ctl.go);
  assert_one_select_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_act && (&hold)) |-> $onehot(~spi_cs_n));
  assert_release_when_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!seq_act && (&hold)) |-> (&spi_cs_n));
  assert_hold_forces_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((~hold) & spi_cs_n) == '0);
endmodule

// File: tb/spi_cmd_engine_tb.sv
module spi_cmd_engine_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       reg_wr;
  logic [4:0] reg_addr;
  logic [7:0] reg_wdata;
  logic [7:0] reg_rdata;
  logic       spi_sck, spi_mosi, spi_miso;
  logic [3:0] spi_cs_n;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  spi_cmd_engine u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .spi_sck(spi_sck),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_cs_n(spi_cs_n)
  );

  // flash model: reply pattern depends on byte position within the frame
  logic       any_low;
  int         bitcnt = 0;
  int         log_n = 0;
  logic [7:0] log_b [16];
  logic [7:0] sh = 8'h00;
  logic [3:0] seen_cs = 4'h0;

  function automatic logic [7:0] pat(input int b);
    return 8'(b * 29 + 91);
  endfunction

  function automatic logic miso_bit(input int c);
    logic [7:0] v;
    v = pat(c / 8);
    return v[7 - (c % 8)];
  endfunction

  assign any_low  = (spi_cs_n != 4'hF);
  assign spi_miso = any_low ? miso_bit(bitcnt) : 1'b0;

  always @(posedge any_low) begin
    bitcnt  = 0;
    log_n   = 0;
    seen_cs = 4'h0;
  end

  always @(posedge spi_sck) begin
    if (any_low) begin
      sh      = {sh[6:0], spi_mosi};
      seen_cs = seen_cs | ~spi_cs_n;
      bitcnt  = bitcnt + 1;
      if (bitcnt % 8 == 0 && log_n < 16) begin
        log_b[log_n] = sh;
        log_n = log_n + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic poll(output int polls);
    logic [7:0] v;
    polls = 0;
    for (int k = 1; k <= 100; k++) begin
      rd(5'h1E, v);
      if (!v[7]) begin polls = k; break; end
      repeat (2) @(negedge clk);
    end
  endtask

  task automatic run_txn(input logic [7:0] opc, input logic [23:0] adr, input logic [31:0] dat,
                         input bit ae, input bit w, input int cnt, input int sel);
    int         polls, hdr, dn, nb;
    logic [7:0] exp_b [8];
    logic [7:0] v;
    wr(5'h16, opc);
    wr(5'h17, adr[7:0]); wr(5'h18, adr[15:8]); wr(5'h19, adr[23:16]);
    for (int j = 0; j < 4; j++) wr(5'(5'h1A + j), w ? dat[8*j +: 8] : 8'hEE);
    wr(5'h1E, 8'h80 | 8'(sel << 5) | (w ? 8'h10 : 8'h00) | (ae ? 8'h08 : 8'h00) | 8'(cnt));
    poll(polls);
    hdr = ae ? 4 : 1;
    dn  = (cnt > 4) ? 4 : cnt;
    nb  = hdr + dn;
    chk(polls == 8 * nb + 1, "R11 done poll", 32'(polls), 32'(8 * nb + 1));
    if (cnt > 4) chk(log_n == nb, "R7 saturated count", 32'(log_n), 32'(nb));
    else         chk(log_n == nb, "R4 byte count", 32'(log_n), 32'(nb));
    exp_b[0] = opc;
    if (ae) begin exp_b[1] = adr[23:16]; exp_b[2] = adr[15:8]; exp_b[3] = adr[7:0]; end
    for (int j = 0; j < dn; j++) exp_b[hdr + j] = w ? dat[8*j +: 8] : 8'h00;
    for (int j = 0; j < nb && j < log_n; j++)
      chk(log_b[j] == exp_b[j], (j < hdr) ? "R4 header byte" : "R6 data out", 32'(log_b[j]), 32'(exp_b[j]));
    if (!w) begin
      for (int j = 0; j < 4; j++) begin
        rd(5'(5'h1A + j), v);
        if (j < dn) chk(v == pat(hdr + j), "R6 read store", 32'(v), 32'(pat(hdr + j)));
        else        chk(v == 8'hEE, "R6 untouched data reg", 32'(v), 32'hEE);
      end
    end
    chk(seen_cs == 4'(1 << sel), "R8 only selected cs", 32'(seen_cs), 32'(1 << sel));
    chk(spi_cs_n == 4'hF, "R8 release at end", 32'(spi_cs_n), 32'hF);
    rd(5'h1E, v);
    chk(v[6:0] == 7'(8'(sel << 5) | (w ? 8'h10 : 8'h00) | (ae ? 8'h08 : 8'h00) | 8'(cnt)),
        "R3 fields kept", 32'(v), 32'(8'(sel << 5)));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int         polls, idx;
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = 5'h00; reg_wdata = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 5'h16; a <= 5'h1E; a++) begin
      rd(5'(a), v);
      chk(v == 8'h00, "R1 reset register", 32'(v), 32'h0);
    end
    rd(5'h1F, v);
    chk(v == 8'h0F, "R1 reset hold", 32'(v), 32'hF);
    chk(spi_cs_n == 4'hF && !spi_sck && !spi_mosi, "R1 reset pins",
        {28'h0, spi_cs_n}, 32'hF);

    // R2 readback and unmapped offset
    wr(5'h16, 8'hA1); wr(5'h17, 8'hB2); wr(5'h19, 8'hC3); wr(5'h1C, 8'hD4);
    rd(5'h16, v); chk(v == 8'hA1, "R2 opcode readback", 32'(v), 32'hA1);
    rd(5'h17, v); chk(v == 8'hB2, "R2 addr low readback", 32'(v), 32'hB2);
    rd(5'h19, v); chk(v == 8'hC3, "R2 addr high readback", 32'(v), 32'hC3);
    rd(5'h1C, v); chk(v == 8'hD4, "R2 data readback", 32'(v), 32'hD4);
    wr(5'h05, 8'h77);
    rd(5'h05, v); chk(v == 8'h00, "R2 unmapped reads zero", 32'(v), 32'h0);

    // R4 R5 R6 R8 R11 sweep over shape, direction, count and select
    idx = 0;
    for (int ae = 0; ae < 2; ae++)
      for (int w = 0; w < 2; w++)
        for (int n = 0; n <= 4; n++) begin
          run_txn(8'(8'h30 + idx), 24'h123456 ^ 24'(idx * 24'h010203),
                  32'hC3A55A3C ^ 32'(idx * 32'h01010101), ae[0], w[0], n, (idx + n) % 4);
          idx++;
        end

    // R7 counts above four
    run_txn(8'h03, 24'h00F00F, 32'h0, 1'b1, 1'b0, 7, 1);
    run_txn(8'h02, 24'h0A0B0C, 32'h11223344, 1'b0, 1'b1, 5, 3);

    // R10 control write while busy; R3 busy flag visible
    wr(5'h16, 8'h5A);
    wr(5'h1E, 8'hBC);
    rd(5'h1E, v);
    chk(v[7], "R3 busy reads one", 32'(v), 32'hBC);
    wr(5'h1E, 8'hE0);
    poll(polls);
    rd(5'h1E, v);
    chk(v == 8'h3C, "R10 busy write ignored", 32'(v), 32'h3C);
    chk(log_n == 8, "R10 frame length kept", 32'(log_n), 32'd8);
    chk(seen_cs == 4'b0010, "R10 select kept", 32'(seen_cs), 32'h2);

    // R9 held frame built from two transfers
    wr(5'h1F, 8'h0B);
    chk(spi_cs_n == 4'b1011, "R9 hold asserts at once", 32'(spi_cs_n), 32'hB);
    wr(5'h16, 8'h06); wr(5'h17, 8'hEF); wr(5'h18, 8'hCD); wr(5'h19, 8'hAB);
    wr(5'h1E, 8'hC8);
    poll(polls);
    chk(spi_cs_n == 4'b1011, "R9 held between transfers", 32'(spi_cs_n), 32'hB);
    wr(5'h16, 8'h9F);
    wr(5'h1E, 8'hC2);
    poll(polls);
    rd(5'h1A, v); chk(v == pat(5), "R9 frame continues byte 0", 32'(v), 32'(pat(5)));
    rd(5'h1B, v); chk(v == pat(6), "R9 frame continues byte 1", 32'(v), 32'(pat(6)));
    chk(log_n == 7, "R9 joined frame length", 32'(log_n), 32'd7);
    chk(log_b[4] == 8'h9F, "R9 second opcode", 32'(log_b[4]), 32'h9F);
    wr(5'h1F, 8'h0F);
    chk(spi_cs_n == 4'hF, "R9 release", 32'(spi_cs_n), 32'hF);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule